// File: doc/BRIEF.md
# Segment Check and Mode Translator

This block sits in front of the address-translation cache of a processor load/store or fetch path. Each cycle it may accept one access: an address that already has the segment base folded in, a byte-size term, write and execute flags, and a 4-bit segment selector. From the current control state (protection enable, paging enable, long-mode-active, and the long-mode bit of the code segment), it decides whether a general-protection fault occurs. It also picks the translation path. The selected segment's attributes, base and limit come from a flat per-segment table.

Real mode and protected mode without paging map the address straight through. Protected mode with paging sends the address to an external translation cache. That cache answers in the same cycle with hit/miss and a physical address, and a miss becomes a page fault that carries the address. Segment permission and limit checks run outside 64-bit mode only. They cover expand-up and expand-down segments, including segments whose limit is below their base. The result (one-hot fault class, path flag, physical and original address) is registered and appears one cycle after the request.

Top module: `seg_xlate_top`

## Requirements
- R1: The segment whose base, limit and attributes are used is the one indexed by `req_seg`. In the attribute table, bit 0 of each 3-bit entry is readable, bit 1 is writable and bit 2 is expand-down, and entry i sits at bits [3i+2:3i].
- R2: With `ctl_prot_en` low, the result is fault-free, `rsp_paddr` equals the request address, and no segment check can fault.
- R3: Segment checks apply only when `ctl_lma` is low or `ctl_cs_long` is low; with both high no general-protection fault is raised.
- R4: A write through a segment whose writable bit is clear raises a general-protection fault.
- R5: A data read (write and execute both low) through a segment whose readable bit is clear faults; an execute access through such a segment does not fault on that account.
- R6: Expand-down clear: when limit < base, the access faults if limit < addr+size and addr < base; otherwise it faults if limit < addr+size.
- R7: Expand-down set: when limit < base, the access faults if addr <= limit or addr+size >= base; otherwise it faults if addr <= limit and addr+size >= base.
- R8: With protection and paging on and no segment fault, `tlb_req_valid` is high. A hit returns `tlb_paddr` in `rsp_paddr` with `rsp_via_tlb` high. A miss raises a page fault, with the request address in `rsp_vaddr`.
- R9: With protection on and paging off, a fault-free result has `rsp_paddr` equal to the request address and `rsp_via_tlb` low.
- R10: `rsp_valid` follows `req_valid` by exactly one cycle. While it is high exactly one of `rsp_ok`, `rsp_gp`, `rsp_pf` is high, and while it is low all three are low.
- R11: addr+size is formed one bit wider than the address, so an access whose end passes the top of the address space is compared without wrapping.
- R12: A general-protection fault takes priority over translation: no lookup is issued (`tlb_req_valid` low), no page fault is reported, `rsp_via_tlb` is low and `rsp_paddr` is zero on any fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | AW | Address with segment base already applied |
| req_size | input | SZW | Size term added to the address for limit checks |
| req_write | input | 1 | Access is a write |
| req_exec | input | 1 | Access is an instruction fetch |
| req_seg | input | SEL_W | Segment selector |
| ctl_prot_en | input | 1 | Protection enabled |
| ctl_page_en | input | 1 | Paging enabled |
| ctl_lma | input | 1 | Long mode active |
| ctl_cs_long | input | 1 | Code segment is a 64-bit segment |
| seg_base_flat | input | 2^SEL_W*AW | Per-segment base values, entry i at [AW*i +: AW] |
| seg_limit_flat | input | 2^SEL_W*AW | Per-segment limit values, entry i at [AW*i +: AW] |
| seg_attr_flat | input | 2^SEL_W*3 | Per-segment attributes (see R1) |
| tlb_req_valid | output | 1 | Lookup request to the external translation cache |
| tlb_req_addr | output | AW | Lookup address |
| tlb_hit | input | 1 | Same-cycle lookup hit |
| tlb_paddr | input | AW | Same-cycle physical address on hit |
| rsp_valid | output | 1 | Registered result valid |
| rsp_ok | output | 1 | No fault |
| rsp_gp | output | 1 | General-protection fault |
| rsp_pf | output | 1 | Page fault (lookup miss) |
| rsp_via_tlb | output | 1 | Result came through the translation cache |
| rsp_paddr | output | AW | Physical address, zero on a fault |
| rsp_vaddr | output | AW | Request address, carried with the result |

## Verification
The hardest situations to reach are those where the limit is below the base, and those where addr+size carries past the top of the address space. Uniform random addresses almost never fall in the narrow window between such a limit and base, or within a few bytes of the top. The random stimulus therefore draws each segment's limit close to its base on either side. It aims addresses at a small window around the base or the limit. Directed cases add the straddling wrapped segments and the carry-out access at the top of memory.

// File: rtl/scm_pkg.sv
package scm_pkg;
  localparam int ATTR_W = 3;

  typedef struct packed {
    logic expdn;   // bit 2
    logic wr;      // bit 1
    logic rd;      // bit 0
  } seg_attr_t;

  typedef enum logic [2:0] {
    FLT_NONE = 3'b001,
    FLT_GP   = 3'b010,
    FLT_PF   = 3'b100
  } flt_e;
endpackage

// File: rtl/scm_seg_select.sv
module scm_seg_select
  import scm_pkg::*;
#(
  parameter int AW    = 32,
  parameter int SEL_W = 4
) (
  input  logic [SEL_W-1:0]                   sel,
  input  logic [(2**SEL_W)*AW-1:0]           base_flat,
  input  logic [(2**SEL_W)*AW-1:0]           limit_flat,
  input  logic [(2**SEL_W)*ATTR_W-1:0]       attr_flat,
  output logic [AW-1:0]                      base,
  output logic [AW-1:0]                      limit,
  output seg_attr_t                          attr
);
  localparam int NSEG = 2**SEL_W;

  logic [AW-1:0] base_a  [NSEG];
  logic [AW-1:0] limit_a [NSEG];
  seg_attr_t     attr_a  [NSEG];

  for (genvar i = 0; i < NSEG; i++) begin : g_unpack
    assign base_a[i]  = base_flat[i*AW +: AW];
    assign limit_a[i] = limit_flat[i*AW +: AW];
    assign attr_a[i]  = seg_attr_t'(attr_flat[i*ATTR_W +: ATTR_W]);
  end

  assign base  = base_a[sel];
  assign limit = limit_a[sel];
  assign attr  = attr_a[sel];
endmodule

// File: rtl/scm_seg_check.sv
module scm_seg_check
  import scm_pkg::*;
#(
  parameter int AW  = 32,
  parameter int SZW = 4
) (
  input  logic            chk_en,
  input  logic [AW-1:0]   addr,
  input  logic [SZW-1:0]  size,
  input  logic            is_write,
  input  logic            is_exec,
  input  logic [AW-1:0]   base,
  input  logic [AW-1:0]   limit,
  input  seg_attr_t       attr,
  output logic            gp
);
  localparam int XW = AW + 1;

  logic [XW-1:0] addr_x, end_x, base_x, lim_x;
  logic          perm_flt, lim_flt, wrapped;

  // R11: end of access is one bit wider than the address
  always_comb begin
    addr_x = {1'b0, addr};
    base_x = {1'b0, base};
    lim_x  = {1'b0, limit};
    end_x  = addr_x + XW'(size);
  end

  // R4, R5: permission checks
  always_comb begin
    perm_flt = 1'b0;
    if (is_write && !attr.wr)                 perm_flt = 1'b1;
    if (!is_write && !is_exec && !attr.rd)    perm_flt = 1'b1;
  end

  // R6, R7: limit checks
  always_comb begin
    wrapped = (lim_x < base_x);
    if (!attr.expdn) begin
      if (wrapped) lim_flt = (lim_x < end_x) && (addr_x < base_x);
      else         lim_flt = (lim_x < end_x);
    end else begin
      if (wrapped) lim_flt = (addr_x <= lim_x) || (end_x >= base_x);
      else         lim_flt = (addr_x <= lim_x) && (end_x >= base_x);
    end
  end

  assign gp = chk_en && (perm_flt || lim_flt);
endmodule

// File: rtl/scm_xlate_path.sv
module scm_xlate_path
  import scm_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          req_valid,
  input  logic [AW-1:0] addr,
  input  logic          prot_en,
  input  logic          page_en,
  input  logic          gp,
  input  logic          tlb_hit,
  input  logic [AW-1:0] tlb_paddr,
  output logic          tlb_req_valid,
  output flt_e          flt,
  output logic          via_tlb,
  output logic [AW-1:0] paddr
);
  // R12: lookup only when no protection fault
  assign tlb_req_valid = req_valid && prot_en && page_en && !gp;

  always_comb begin
    flt     = FLT_NONE;
    via_tlb = 1'b0;
    paddr   = addr;
    if (prot_en) begin
      if (gp) begin
        flt   = FLT_GP;
        paddr = '0;
      end else if (page_en) begin
        via_tlb = 1'b1;
        if (tlb_hit) begin
          paddr = tlb_paddr;
        end else begin
          flt   = FLT_PF;
          paddr = '0;
        end
      end
    end
  end
endmodule

// File: rtl/seg_xlate_top.sv
module seg_xlate_top
  import scm_pkg::*;
#(
  parameter int AW    = 32,
  parameter int SZW   = 4,
  parameter int SEL_W = 4
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               req_valid,
  input  logic [AW-1:0]                      req_addr,
  input  logic [SZW-1:0]                     req_size,
  input  logic                               req_write,
  input  logic                               req_exec,
  input  logic [SEL_W-1:0]                   req_seg,
  input  logic                               ctl_prot_en,
  input  logic                               ctl_page_en,
  input  logic                               ctl_lma,
  input  logic                               ctl_cs_long,
  input  logic [(2**SEL_W)*AW-1:0]           seg_base_flat,
  input  logic [(2**SEL_W)*AW-1:0]           seg_limit_flat,
  input  logic [(2**SEL_W)*3-1:0]            seg_attr_flat,
  output logic                               tlb_req_valid,
  output logic [AW-1:0]                      tlb_req_addr,
  input  logic                               tlb_hit,
  input  logic [AW-1:0]                      tlb_paddr,
  output logic                               rsp_valid,
  output logic                               rsp_ok,
  output logic                               rsp_gp,
  output logic                               rsp_pf,
  output logic                               rsp_via_tlb,
  output logic [AW-1:0]                      rsp_paddr,
  output logic [AW-1:0]                      rsp_vaddr
);
  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  logic [AW-1:0] sel_base, sel_limit;
  seg_attr_t     sel_attr;
  logic          chk_en, gp_c, via_c;
  flt_e          flt_c;
  logic [AW-1:0] paddr_c;

  scm_seg_select #(.AW(AW), .SEL_W(SEL_W)) u_sel (
    .sel(req_seg), .base_flat(seg_base_flat), .limit_flat(seg_limit_flat),
    .attr_flat(seg_attr_flat), .base(sel_base), .limit(sel_limit), .attr(sel_attr)
  );

  // R3: checks outside 64-bit mode only, and only with protection on (R2)
  assign chk_en = ctl_prot_en && (!ctl_lma || !ctl_cs_long);

  scm_seg_check #(.AW(AW), .SZW(SZW)) u_chk (
    .chk_en(chk_en), .addr(req_addr), .size(req_size), .is_write(req_write),
    .is_exec(req_exec), .base(sel_base), .limit(sel_limit), .attr(sel_attr),
    .gp(gp_c)
  );

  scm_xlate_path #(.AW(AW)) u_path (
    .req_valid(req_valid), .addr(req_addr), .prot_en(ctl_prot_en),
    .page_en(ctl_page_en), .gp(gp_c), .tlb_hit(tlb_hit), .tlb_paddr(tlb_paddr),
    .tlb_req_valid(tlb_req_valid), .flt(flt_c), .via_tlb(via_c), .paddr(paddr_c)
  );
  assign tlb_req_addr = req_addr;

  // result stage: next-state and register processes
  logic          vld_q, vld_d;
  flt_e          flt_q, flt_d;
  logic          via_q, via_d;
  logic [AW-1:0] pa_q, pa_d, va_q, va_d;

  always_comb begin
    vld_d = req_valid;
    flt_d = flt_q;
    via_d = via_q;
    pa_d  = pa_q;
    va_d  = va_q;
    if (req_valid) begin
      flt_d = flt_c;
      via_d = via_c;
      pa_d  = paddr_c;
      va_d  = req_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      vld_q <= 1'b0;
      flt_q <= FLT_NONE;
      via_q <= 1'b0;
      pa_q  <= '0;
      va_q  <= '0;
    end else begin
      vld_q <= vld_d;
      flt_q <= flt_d;
      via_q <= via_d;
      pa_q  <= pa_d;
      va_q  <= va_d;
    end
  end

  assign rsp_valid   = vld_q;
  assign rsp_ok      = vld_q && (flt_q == FLT_NONE);
  assign rsp_gp      = vld_q && (flt_q == FLT_GP);
  assign rsp_pf      = vld_q && (flt_q == FLT_PF);
  assign rsp_via_tlb = vld_q && via_q;
  assign rsp_paddr   = pa_q;
  assign rsp_vaddr   = va_q;

  // assertions
  p_valid_lat_r10: assert property (@(posedge clk) disable iff (!rst_n_s)
    req_valid |=> rsp_valid);
  p_idle_lat_r10: assert property (@(posedge clk) disable iff (!rst_n_s)
    !req_valid |=> !rsp_valid);
  p_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n_s)
    rsp_valid |-> $countones({rsp_ok, rsp_gp, rsp_pf}) == 1);
  p_real_ident_r2: assert property (@(posedge clk) disable iff (!rst_n_s)
    (req_valid && !ctl_prot_en) |=> (rsp_ok && rsp_paddr == $past(req_addr)));
  p_bypass_r3: assert property (@(posedge clk) disable iff (!rst_n_s)
    (req_valid && ctl_lma && ctl_cs_long) |=> !rsp_gp);
  p_wr_perm_r4: assert property (@(posedge clk) disable iff (!rst_n_s)
    (req_valid && chk_en && req_write && !sel_attr.wr) |=> rsp_gp);
  p_gp_no_lookup_r12: assert property (@(posedge clk) disable iff (!rst_n_s)
    gp_c |-> !tlb_req_valid);
  p_miss_pf_r8: assert property (@(posedge clk) disable iff (!rst_n_s)
    (tlb_req_valid && !tlb_hit) |=> (rsp_pf && rsp_vaddr == $past(req_addr)));
endmodule

// File: tb/seg_xlate_top_tb_top.sv
module seg_xlate_top_tb_top;
  localparam int AW = 32;
  localparam int NSEG = 16;

  logic clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  logic rst_n;
  logic req_valid, req_write, req_exec;
  logic [31:0] req_addr;
  logic [3:0]  req_size, req_seg;
  logic ctl_prot_en, ctl_page_en, ctl_lma, ctl_cs_long;
  logic [NSEG*32-1:0] seg_base_flat, seg_limit_flat;
  logic [NSEG*3-1:0]  seg_attr_flat;
  logic tlb_req_valid, tlb_hit;
  logic [31:0] tlb_req_addr, tlb_paddr;
  logic rsp_valid, rsp_ok, rsp_gp, rsp_pf, rsp_via_tlb;
  logic [31:0] rsp_paddr, rsp_vaddr;

  logic [31:0] tb_base  [NSEG];
  logic [31:0] tb_limit [NSEG];
  logic [2:0]  tb_attr  [NSEG];   // {expdn, wr, rd}

  always_comb begin
    for (int i = 0; i < NSEG; i++) begin
      seg_base_flat[i*32 +: 32] = tb_base[i];
      seg_limit_flat[i*32 +: 32] = tb_limit[i];
      seg_attr_flat[i*3 +: 3]   = tb_attr[i];
    end
  end

  // external translation cache model
  function automatic logic tlb_model_hit(input logic [31:0] a);
    return a[13] == 1'b0;
  endfunction
  function automatic logic [31:0] tlb_model_pa(input logic [31:0] a);
    return {a[31:12] ^ 20'h5A5A5, a[11:0]};
  endfunction
  assign tlb_hit   = tlb_model_hit(tlb_req_addr);
  assign tlb_paddr = tlb_model_pa(tlb_req_addr);

  seg_xlate_top #(.AW(32), .SZW(4), .SEL_W(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_size(req_size), .req_write(req_write), .req_exec(req_exec),
    .req_seg(req_seg), .ctl_prot_en(ctl_prot_en), .ctl_page_en(ctl_page_en),
    .ctl_lma(ctl_lma), .ctl_cs_long(ctl_cs_long), .seg_base_flat(seg_base_flat),
    .seg_limit_flat(seg_limit_flat), .seg_attr_flat(seg_attr_flat),
    .tlb_req_valid(tlb_req_valid), .tlb_req_addr(tlb_req_addr),
    .tlb_hit(tlb_hit), .tlb_paddr(tlb_paddr), .rsp_valid(rsp_valid),
    .rsp_ok(rsp_ok), .rsp_gp(rsp_gp), .rsp_pf(rsp_pf),
    .rsp_via_tlb(rsp_via_tlb), .rsp_paddr(rsp_paddr), .rsp_vaddr(rsp_vaddr)
  );

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  // expected values
  logic exp_ok, exp_gp, exp_pf, exp_via, exp_lookup;
  logic [31:0] exp_pa;
  string exp_tag;

  function automatic void predict();
    logic chk, perm, limf, wrapped;
    logic [32:0] a, e, b, l;
    logic [2:0] at;
    at = tb_attr[req_seg];
    a = {1'b0, req_addr};
    e = a + 33'(req_size);
    b = {1'b0, tb_base[req_seg]};
    l = {1'b0, tb_limit[req_seg]};
    chk = ctl_prot_en && (!ctl_lma || !ctl_cs_long);
    perm = (req_write && !at[1]) || (!req_write && !req_exec && !at[0]);
    wrapped = l < b;
    if (!at[2]) limf = wrapped ? ((l < e) && (a < b)) : (l < e);
    else        limf = wrapped ? ((a <= l) || (e >= b)) : ((a <= l) && (e >= b));
    exp_ok = 1'b0; exp_gp = 1'b0; exp_pf = 1'b0; exp_via = 1'b0;
    exp_pa = 32'h0; exp_lookup = 1'b0;
    if (!ctl_prot_en) begin
      exp_ok = 1'b1; exp_pa = req_addr; exp_tag = "R2";
    end else if (chk && (perm || limf)) begin
      exp_gp = 1'b1;
      if (perm) exp_tag = req_write ? "R4" : "R5";
      else if (e[32]) exp_tag = "R11";
      else exp_tag = at[2] ? "R7" : "R6";
    end else if (ctl_page_en) begin
      exp_lookup = 1'b1; exp_via = 1'b1; exp_tag = chk ? "R8" : "R3";
      if (tlb_model_hit(req_addr)) begin
        exp_ok = 1'b1; exp_pa = tlb_model_pa(req_addr);
      end else exp_pf = 1'b1;
    end else begin
      exp_ok = 1'b1; exp_pa = req_addr; exp_tag = chk ? "R9" : "R3";
    end
  endfunction

  // call at a negedge; returns at the following negedge
  task automatic do_req(input logic [31:0] a, input logic [3:0] sz,
                        input logic wr, input logic ex, input logic [3:0] s,
                        input string tag_override);
    req_valid = 1'b1; req_addr = a; req_size = sz;
    req_write = wr; req_exec = ex; req_seg = s;
    predict();
    if (tag_override != "") exp_tag = tag_override;
    #1;
    n_chk++;
    if (tlb_req_valid !== exp_lookup) begin
      n_err++;
      $display("FAIL R12 lookup request: got %b expected %b (addr %h)",
               tlb_req_valid, exp_lookup, a);
    end
    @(negedge clk);
    n_chk++;
    if ({rsp_valid, rsp_ok, rsp_gp, rsp_pf, rsp_via_tlb} !==
        {1'b1, exp_ok, exp_gp, exp_pf, exp_via} || rsp_paddr !== exp_pa ||
        rsp_vaddr !== a) begin
      n_err++;
      $display("FAIL %s addr %h: got v/ok/gp/pf/via=%b%b%b%b%b pa=%h va=%h expected 1%b%b%b%b pa=%h va=%h",
               exp_tag, a, rsp_valid, rsp_ok, rsp_gp, rsp_pf, rsp_via_tlb,
               rsp_paddr, rsp_vaddr, exp_ok, exp_gp, exp_pf, exp_via, exp_pa, a);
    end
  endtask

  task automatic idle_check();
    req_valid = 1'b0;
    @(negedge clk);
    n_chk++;
    if ({rsp_valid, rsp_ok, rsp_gp, rsp_pf} !== 4'b0000) begin
      n_err++;
      $display("FAIL R10 idle: got v/ok/gp/pf=%b%b%b%b expected 0000",
               rsp_valid, rsp_ok, rsp_gp, rsp_pf);
    end
  endtask

  task automatic set_mode(input logic p, input logic pg, input logic l, input logic c);
    ctl_prot_en = p; ctl_page_en = pg; ctl_lma = l; ctl_cs_long = c;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    n_chk++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    req_valid = 0; req_addr = 0; req_size = 0; req_write = 0; req_exec = 0; req_seg = 0;
    set_mode(0, 0, 0, 0);
    for (int i = 0; i < NSEG; i++) begin
      tb_base[i] = 32'h0; tb_limit[i] = 32'hFFFF_FFFF; tb_attr[i] = 3'b011;
    end
    repeat (4) @(negedge clk);
    n_chk++;
    if ({rsp_valid, rsp_ok, rsp_gp, rsp_pf} !== 4'b0000) begin
      n_err++;
      $display("FAIL R10 reset: got %b expected 0000", {rsp_valid, rsp_ok, rsp_gp, rsp_pf});
    end
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    idle_check();

    // R2: real mode ignores an unreadable, unwritable segment
    tb_attr[2] = 3'b000; tb_limit[2] = 32'h10;
    set_mode(0, 1, 0, 0);
    do_req(32'h0000_5000, 4'd4, 1'b1, 1'b0, 4'd2, "R2");
    do_req(32'h0000_5000, 4'd4, 1'b0, 1'b0, 4'd2, "R2");

    // R1: selector picks the entry
    tb_attr[3] = 3'b011; tb_attr[5] = 3'b001;
    set_mode(1, 0, 0, 0);
    do_req(32'h0000_0100, 4'd4, 1'b1, 1'b0, 4'd3, "R1");
    do_req(32'h0000_0100, 4'd4, 1'b1, 1'b0, 4'd5, "R1");
    idle_check();

    // R4, R5
    do_req(32'h0000_0100, 4'd2, 1'b1, 1'b0, 4'd5, "R4");
    tb_attr[6] = 3'b010;
    do_req(32'h0000_0100, 4'd2, 1'b0, 1'b0, 4'd6, "R5");
    do_req(32'h0000_0100, 4'd2, 1'b0, 1'b1, 4'd6, "R5");

    // R3: 64-bit mode bypasses checks, otherwise they apply
    set_mode(1, 0, 1, 1);
    do_req(32'h0000_0100, 4'd2, 1'b1, 1'b0, 4'd5, "R3");
    set_mode(1, 0, 1, 0);
    do_req(32'h0000_0100, 4'd2, 1'b1, 1'b0, 4'd5, "R3");
    set_mode(1, 1, 1, 1);
    do_req(32'h0000_0100, 4'd2, 1'b1, 1'b0, 4'd5, "R3");

    // R6: expand-up wrapped and normal
    set_mode(1, 0, 0, 0);
    tb_base[7] = 32'h1000; tb_limit[7] = 32'h0800; tb_attr[7] = 3'b011;
    do_req(32'h0000_0900, 4'd4, 1'b0, 1'b0, 4'd7, "R6");
    do_req(32'h0000_1100, 4'd4, 1'b0, 1'b0, 4'd7, "R6");
    do_req(32'h0000_0100, 4'd4, 1'b0, 1'b0, 4'd7, "R6");
    tb_base[7] = 32'h0; tb_limit[7] = 32'h0FFF;
    do_req(32'h0000_0FFC, 4'd4, 1'b0, 1'b0, 4'd7, "R6");
    do_req(32'h0000_0FFC, 4'd3, 1'b0, 1'b0, 4'd7, "R6");

    // R7: expand-down normal and wrapped
    tb_base[8] = 32'h0100; tb_limit[8] = 32'h1000; tb_attr[8] = 3'b111;
    do_req(32'h0000_0800, 4'd4, 1'b1, 1'b0, 4'd8, "R7");
    do_req(32'h0000_2000, 4'd4, 1'b1, 1'b0, 4'd8, "R7");
    tb_base[8] = 32'h3000; tb_limit[8] = 32'h1000;
    do_req(32'h0000_2000, 4'd4, 1'b1, 1'b0, 4'd8, "R7");
    do_req(32'h0000_0F00, 4'd4, 1'b1, 1'b0, 4'd8, "R7");
    do_req(32'h0000_2FFC, 4'd4, 1'b1, 1'b0, 4'd8, "R7");

    // R11: carry past the top of the address space
    tb_base[9] = 32'h0; tb_limit[9] = 32'hFFFF_FFFF; tb_attr[9] = 3'b011;
    do_req(32'hFFFF_FFF8, 4'd15, 1'b0, 1'b0, 4'd9, "R11");
    do_req(32'hFFFF_FFF0, 4'd15, 1'b0, 1'b0, 4'd9, "R11");

    // R8, R9, R12
    set_mode(1, 1, 0, 0);
    do_req(32'h1234_0100, 4'd4, 1'b0, 1'b0, 4'd9, "R8");
    do_req(32'h1234_2100, 4'd4, 1'b0, 1'b0, 4'd9, "R8");
    do_req(32'h1234_2100, 4'd4, 1'b1, 1'b0, 4'd5, "R12");
    set_mode(1, 0, 0, 0);
    do_req(32'h1234_2100, 4'd4, 1'b0, 1'b0, 4'd9, "R9");
    idle_check();

    // constrained random
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] a;
      int s;
      if (n % 40 == 0) begin
        for (int i = 0; i < NSEG; i++) begin
          int kind;
          tb_base[i] = $urandom;
          kind = $urandom % 4;
          case (kind)
            0: tb_limit[i] = tb_base[i] + ($urandom % 512);
            1: tb_limit[i] = tb_base[i] - ($urandom % 512) - 1;
            2: tb_limit[i] = $urandom;
            default: begin tb_base[i] = 32'hFFFF_FF00; tb_limit[i] = 32'hFFFF_FFFF; end
          endcase
          tb_attr[i] = 3'($urandom);
        end
      end
      if (n % 7 == 0) set_mode(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
      else if (n % 7 == 1) set_mode(1, $urandom % 2 == 0, 0, 0);
      s = $urandom % NSEG;
      if ($urandom % 2 == 0) a = tb_base[s] + ($urandom % 1024) - 512;
      else                   a = tb_limit[s] + ($urandom % 32) - 16;
      if ($urandom % 9 == 0) idle_check();
      do_req(a, 4'($urandom), 1'($urandom), $urandom % 4 == 0, 4'(s), "");
    end
    idle_check();
    finish_run();
  end
endmodule